// File: doc/BRIEF.md
# Isolated Page-Table Walker

This block resolves a virtual page number into its final page-table entry after a translation lookaside miss. It walks a four-level radix table whose root is given by `root_ppn`, and it never routes a table read through the shared data cache. Every entry it needs comes either from a small private PTE store inside the walker or from an uncached 64-bit read on its own memory port. Ordinary loads and stores cannot reach this store, so they can neither fill it nor push entries out of it. Software sees the same translations either way.

A request carries a 36-bit VPN, split into four 9-bit slices, one per level. At each level the walker forms the entry address, probes the private store, and reads memory only on a miss. A returned entry that is valid is written into the store. A walk ends with the leaf entry and the level where it was found, or with a fault. A runtime switch selects a fully uncached mode that skips the store entirely. A flush input empties the store. If a walk is in progress, the flush waits until that walk has finished.

Top module: `pte_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0.
- R2: The top-level entry address is `root_ppn`*4096 + `req_vpn[35:27]`*8. Each lower level uses (entry bits [53:10])*4096 + (the next lower 9-bit VPN slice)*8, with `req_vpn[8:0]` used at level 0. A full walk makes at most four memory reads.
- R3: Entry bit 0 is the valid bit, bit 1 is read permission and bit 3 is execute permission. A valid entry with bit 1 or bit 3 set is a leaf. The walk then ends early, returning that entry in `resp_pte` and its level in `resp_level` (3 = top, 0 = last).
- R4: A walk ends with `resp_fault`=1 when it meets an entry whose valid bit is clear, or when the level-0 entry is valid but not a leaf.
- R5: With `mode_uncached`=0, an entry fetched earlier and still held in the private store is served without a memory read.
- R6: An entry returned from memory with bit 0 clear is never placed in the private store.
- R7: With `mode_uncached`=1, every level of a walk reads memory, and the private store is neither consulted nor written. Entries stored before the switch are still served once the mode returns to 0.
- R8: The private store holds 16 entries, matched by entry physical address. After a flush, fills go to slots 0, 1, 2, … in turn, and each fill replaces the slot after the one filled last, wrapping from 15 to 0.
- R9: A `flush_req` pulse while the walker is idle empties the store at that clock edge. A pulse during a walk has no effect on that walk and empties the store as soon as the walker returns to idle.
- R10: A walk whose top-level entry is a leaf held in the store raises `resp_valid` on the third clock edge after the request is accepted.
- R11: Only one memory read is outstanding at a time. `mem_req_addr` holds steady while `mem_req_valid` waits for `mem_req_ready`.
- R12: `resp_valid` lasts a single cycle, and `req_ready` is low whenever `resp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_uncached | input | 1 | 1: every entry read goes to memory, private store unused |
| flush_req | input | 1 | Pulse to empty the private store |
| root_ppn | input | 44 | Page number of the top-level table |
| req_valid | input | 1 | Walk request present |
| req_vpn | input | 36 | Virtual page number to translate |
| req_ready | output | 1 | Walker idle and accepting a request |
| resp_valid | output | 1 | Walk result valid (one cycle) |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_level | output | 2 | Level of the returned entry |
| resp_pte | output | 64 | Returned entry |
| mem_req_valid | output | 1 | Uncached read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry data returned by memory |

## Verification
The hardest case to reach from the ports is a flush that lands in the middle of a walk. The deferral only shows if the walk depends on entries the flush would otherwise remove. The bench first warms the store with a complete four-level walk. It then repeats that walk and pulses `flush_req` two cycles after acceptance, while the walker alternates between probing and evaluating. The repeated walk must finish with no memory read, and the walk after it must read all four levels. Round-robin replacement is reached by filling all 16 slots with single-level superpage walks. Further misses then show which slot was replaced, through hit or miss read counts on entries chosen for that purpose.

// File: rtl/pw_pkg.sv
package pw_pkg;

   // Bit positions inside a page-table entry
   localparam int PTE_V_BIT   = 0;
   localparam int PTE_R_BIT   = 1;
   localparam int PTE_X_BIT   = 3;
   localparam int PTE_PPN_LSB = 10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_MEMREQ,
      ST_MEMWAIT,
      ST_NEXT,
      ST_DONE
   } walk_state_t;

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
   parameter int LEVELS     = 4,
   parameter int SLICE_W    = 9,
   parameter int PPN_W      = 44,
   parameter int PAGE_SHIFT = 12,
   parameter int ENTRY_LOG2 = 3,
   localparam int VPN_W     = LEVELS * SLICE_W,
   localparam int PA_W      = PPN_W + PAGE_SHIFT,
   localparam int LVL_W     = $clog2(LEVELS)
) (
   input  logic [PPN_W-1:0] base_ppn,
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] level,
   output logic [PA_W-1:0]  entry_addr
);

   logic [SLICE_W-1:0] slices [LEVELS];
   logic [SLICE_W-1:0] sel_slice;

   for (genvar g = 0; g < LEVELS; g++) begin : g_slice
      assign slices[g] = vpn[g*SLICE_W +: SLICE_W];
   end

   assign sel_slice  = slices[level];
   assign entry_addr = {base_ppn, {PAGE_SHIFT{1'b0}}}
                     | PA_W'({sel_slice, {ENTRY_LOG2{1'b0}}});

endmodule

// File: rtl/pw_pte_cache.sv
module pw_pte_cache #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 53,
   parameter int DATA_W  = 64,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [TAG_W-1:0]  probe_tag,
   output logic              hit,
   output logic [DATA_W-1:0] hit_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data
);

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [IDX_W-1:0]   victim_q;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == probe_tag);
   end

   assign hit = |match;

   always_comb begin
      hit_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) hit_data = hit_data | data_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld_q    <= '0;
         victim_q <= '0;
      end else if (fill_en) begin
         vld_q[victim_q] <= 1'b1;
         if (victim_q == IDX_W'(ENTRIES - 1)) victim_q <= '0;
         else                                 victim_q <= victim_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[victim_q]  <= fill_tag;
         data_q[victim_q] <= fill_data;
      end
   end

endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
   import pw_pkg::*;
#(
   parameter int LEVELS     = 4,
   parameter int SLICE_W    = 9,
   parameter int PPN_W      = 44,
   parameter int PAGE_SHIFT = 12,
   parameter int PTE_W      = 64,
   localparam int VPN_W     = LEVELS * SLICE_W,
   localparam int PA_W      = PPN_W + PAGE_SHIFT,
   localparam int LVL_W     = $clog2(LEVELS),
   localparam int ENTRY_LOG2 = $clog2(PTE_W / 8),
   localparam int TAG_W     = PA_W - ENTRY_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_uncached,
   input  logic [PPN_W-1:0]  root_ppn,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   output logic              req_ready,
   output logic              resp_valid,
   output logic              resp_fault,
   output logic [LVL_W-1:0]  resp_level,
   output logic [PTE_W-1:0]  resp_pte,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic [TAG_W-1:0]  probe_tag,
   input  logic              probe_hit,
   input  logic [PTE_W-1:0]  probe_data,
   output logic              fill_en,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [PTE_W-1:0]  fill_data
);

   walk_state_t       state_q;
   logic [LVL_W-1:0]  level_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [PA_W-1:0]   addr_q;
   logic [PTE_W-1:0]  pte_q;
   logic              fault_q;

   logic [PPN_W-1:0]  ag_ppn;
   logic [VPN_W-1:0]  ag_vpn;
   logic [LVL_W-1:0]  ag_level;
   logic [PA_W-1:0]   ag_addr;

   logic pte_valid, pte_leaf, use_store;

   assign pte_valid = pte_q[PTE_V_BIT];
   assign pte_leaf  = pte_q[PTE_R_BIT] | pte_q[PTE_X_BIT];
   assign use_store = !mode_uncached;

   // Address source: root at acceptance, current entry afterwards
   always_comb begin
      if (state_q == ST_IDLE) begin
         ag_ppn   = root_ppn;
         ag_vpn   = req_vpn;
         ag_level = LVL_W'(LEVELS - 1);
      end else begin
         ag_ppn   = pte_q[PTE_PPN_LSB +: PPN_W];
         ag_vpn   = vpn_q;
         ag_level = level_q - 1'b1;
      end
   end

   pw_addr_gen #(
      .LEVELS     (LEVELS),
      .SLICE_W    (SLICE_W),
      .PPN_W      (PPN_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .ENTRY_LOG2 (ENTRY_LOG2)
   ) u_addr (
      .base_ppn   (ag_ppn),
      .vpn        (ag_vpn),
      .level      (ag_level),
      .entry_addr (ag_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         level_q <= '0;
         vpn_q   <= '0;
         addr_q  <= '0;
         pte_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vpn_q   <= req_vpn;
                  level_q <= LVL_W'(LEVELS - 1);
                  addr_q  <= ag_addr;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (use_store && probe_hit) begin
                  pte_q   <= probe_data;
                  state_q <= ST_NEXT;
               end else begin
                  state_q <= ST_MEMREQ;
               end
            end
            ST_MEMREQ: begin
               if (mem_req_ready) state_q <= ST_MEMWAIT;
            end
            ST_MEMWAIT: begin
               if (mem_rsp_valid) begin
                  pte_q   <= mem_rsp_data;
                  state_q <= ST_NEXT;
               end
            end
            ST_NEXT: begin
               if (!pte_valid) begin
                  fault_q <= 1'b1;
                  state_q <= ST_DONE;
               end else if (pte_leaf) begin
                  fault_q <= 1'b0;
                  state_q <= ST_DONE;
               end else if (level_q == '0) begin
                  fault_q <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  level_q <= level_q - 1'b1;
                  addr_q  <= ag_addr;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign resp_valid    = (state_q == ST_DONE);
   assign resp_fault    = fault_q;
   assign resp_level    = level_q;
   assign resp_pte      = pte_q;
   assign mem_req_valid = (state_q == ST_MEMREQ);
   assign mem_req_addr  = addr_q;

   assign probe_tag = addr_q[PA_W-1:ENTRY_LOG2];
   assign fill_en   = (state_q == ST_MEMWAIT) && mem_rsp_valid && use_store
                    && mem_rsp_data[PTE_V_BIT];
   assign fill_tag  = addr_q[PA_W-1:ENTRY_LOG2];
   assign fill_data = mem_rsp_data;

endmodule

// File: rtl/pte_walker.sv
module pte_walker #(
   parameter int LEVELS           = 4,
   parameter int SLICE_W          = 9,
   parameter int PPN_W            = 44,
   parameter int PAGE_SHIFT       = 12,
   parameter int PTE_W            = 64,
   parameter int CACHE_ENTRIES    = 16,
   parameter bit ENABLE_PTE_CACHE = 1'b1,
   localparam int VPN_W      = LEVELS * SLICE_W,
   localparam int PA_W       = PPN_W + PAGE_SHIFT,
   localparam int LVL_W      = $clog2(LEVELS),
   localparam int ENTRY_LOG2 = $clog2(PTE_W / 8),
   localparam int TAG_W      = PA_W - ENTRY_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_uncached,
   input  logic              flush_req,
   input  logic [PPN_W-1:0]  root_ppn,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   output logic              req_ready,
   output logic              resp_valid,
   output logic              resp_fault,
   output logic [LVL_W-1:0]  resp_level,
   output logic [PTE_W-1:0]  resp_pte,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data
);

   // Elaboration-time parameter checks
   if (LEVELS < 2 || (1 << LVL_W) != LEVELS) begin : g_chk_levels
      $error("LEVELS must be a power of two, at least 2");
   end
   if (SLICE_W + ENTRY_LOG2 > PAGE_SHIFT) begin : g_chk_slice
      $error("VPN slice times entry size must fit inside one page");
   end
   if (pw_pkg::PTE_PPN_LSB + PPN_W > PTE_W) begin : g_chk_ppn
      $error("PPN field does not fit inside the entry");
   end
   if (CACHE_ENTRIES < 2) begin : g_chk_entries
      $error("CACHE_ENTRIES must be at least 2");
   end

   logic             probe_hit;
   logic [PTE_W-1:0] probe_data;
   logic [TAG_W-1:0] probe_tag;
   logic             fill_en;
   logic [TAG_W-1:0] fill_tag;
   logic [PTE_W-1:0] fill_data;
   logic             flush_pend_q;
   logic             cache_flush;

   // Flush is applied only while idle; a request mid-walk is held
   assign cache_flush = req_ready && (flush_req || flush_pend_q);

   always_ff @(posedge clk) begin
      if (!rst_n)           flush_pend_q <= 1'b0;
      else if (cache_flush) flush_pend_q <= 1'b0;
      else if (flush_req)   flush_pend_q <= 1'b1;
   end

   pw_walk_fsm #(
      .LEVELS     (LEVELS),
      .SLICE_W    (SLICE_W),
      .PPN_W      (PPN_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .PTE_W      (PTE_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_uncached (mode_uncached),
      .root_ppn      (root_ppn),
      .req_valid     (req_valid),
      .req_vpn       (req_vpn),
      .req_ready     (req_ready),
      .resp_valid    (resp_valid),
      .resp_fault    (resp_fault),
      .resp_level    (resp_level),
      .resp_pte      (resp_pte),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .probe_tag     (probe_tag),
      .probe_hit     (probe_hit),
      .probe_data    (probe_data),
      .fill_en       (fill_en),
      .fill_tag      (fill_tag),
      .fill_data     (fill_data)
   );

   if (ENABLE_PTE_CACHE) begin : g_store
      pw_pte_cache #(
         .ENTRIES (CACHE_ENTRIES),
         .TAG_W   (TAG_W),
         .DATA_W  (PTE_W)
      ) u_store (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (cache_flush),
         .probe_tag (probe_tag),
         .hit       (probe_hit),
         .hit_data  (probe_data),
         .fill_en   (fill_en),
         .fill_tag  (fill_tag),
         .fill_data (fill_data)
      );
   end else begin : g_nostore
      assign probe_hit  = 1'b0;
      assign probe_data = '0;
   end

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
   parameter int LEVELS = 4,
   parameter int LVL_W  = 2,
   parameter int PA_W   = 56
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_uncached,
   input logic             req_valid,
   input logic             req_ready,
   input logic             resp_valid,
   input logic             resp_fault,
   input logic [LVL_W-1:0] resp_level,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             mem_rsp_valid,
   input logic             cache_flush
);

   localparam int CNT_W = $clog2(LEVELS + 1) + 1;

   logic [1:0]       out_cnt;
   logic [CNT_W-1:0] rd_cnt;
   logic             unc_all;
   logic             hs;

   assign hs = mem_req_valid && mem_req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_cnt <= '0;
         rd_cnt  <= '0;
         unc_all <= 1'b0;
      end else begin
         if (hs && !mem_rsp_valid)                     out_cnt <= out_cnt + 1'b1;
         else if (!hs && mem_rsp_valid && out_cnt != 0) out_cnt <= out_cnt - 1'b1;

         if (req_valid && req_ready) rd_cnt <= '0;
         else if (hs)                rd_cnt <= rd_cnt + 1'b1;

         if (req_valid && req_ready) unc_all <= mode_uncached;
         else if (!mode_uncached)    unc_all <= 1'b0;
      end
   end

   AST_RESP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);                                    // R12
   AST_NOT_READY_ON_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !req_ready);                                     // R12
   AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> out_cnt == 2'd0);                             // R11
   AST_READS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> int'(rd_cnt) <= LEVELS);                         // R2
   AST_UNCACHED_READS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_fault && unc_all
         |-> int'(rd_cnt) == LEVELS - int'(resp_level));              // R7
   AST_FLUSH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cache_flush |-> req_ready);                                     // R9

endmodule

bind pte_walker pw_checker #(
   .LEVELS (LEVELS),
   .LVL_W  (LVL_W),
   .PA_W   (PA_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_uncached (mode_uncached),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .resp_valid    (resp_valid),
   .resp_fault    (resp_fault),
   .resp_level    (resp_level),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_rsp_valid (mem_rsp_valid),
   .cache_flush   (cache_flush)
);

// File: tb/tb_pte_walker.sv
module tb_pte_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_uncached = 1'b0;
   logic        flush_req = 1'b0;
   logic [43:0] root_ppn = 44'h100;
   logic        req_valid = 1'b0;
   logic [35:0] req_vpn = '0;
   logic        req_ready;
   logic        resp_valid;
   logic        resp_fault;
   logic [1:0]  resp_level;
   logic [63:0] resp_pte;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [55:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;

   always #5 clk = ~clk;

   pte_walker dut (
      .clk (clk), .rst_n (rst_n), .mode_uncached (mode_uncached),
      .flush_req (flush_req), .root_ppn (root_ppn),
      .req_valid (req_valid), .req_vpn (req_vpn), .req_ready (req_ready),
      .resp_valid (resp_valid), .resp_fault (resp_fault),
      .resp_level (resp_level), .resp_pte (resp_pte),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
      .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data)
   );

   int n_chk = 0;
   int n_bad = 0;

   // ---------------- memory model (two-cycle read) ----------------
   logic [63:0] pmem [logic [55:0]];
   logic [55:0] pend_addr = '0;
   logic [55:0] last_addr = '0;
   int          dly = 0;
   int          rd_total = 0;

   function automatic logic [63:0] mem_read(input logic [55:0] a);
      if (pmem.exists(a)) return pmem[a];
      return 64'd0;
   endfunction

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (dly != 0) begin
         dly <= dly - 1;
         if (dly == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_read(pend_addr);
         end
      end
      if (mem_req_valid && mem_req_ready) begin
         pend_addr <= mem_req_addr;
         last_addr <= mem_req_addr;
         dly       <= 2;
         rd_total  <= rd_total + 1;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [55:0] eaddr(input logic [43:0] ppn, input int idx);
      return {ppn, 12'h000} + 56'(idx * 8);
   endfunction
   function automatic logic [63:0] mk_ptr(input logic [43:0] ppn);
      return (64'(ppn) << 10) | 64'h1;
   endfunction
   function automatic logic [63:0] mk_leaf(input logic [43:0] ppn, input logic [3:0] perm);
      return (64'(ppn) << 10) | 64'(perm);
   endfunction
   function automatic logic [35:0] mk_vpn(input int a, input int b, input int c, input int d);
      return {9'(a), 9'(b), 9'(c), 9'(d)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   logic        w_fault;
   logic [1:0]  w_lvl;
   logic [63:0] w_pte;
   int          w_reads;
   int          w_lat;

   // Issues one walk; starts and ends on a negative edge with the walker idle
   task automatic walk(input logic [35:0] vpn, input int flush_at);
      int start;
      int guard;
      guard = 0;
      while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
      req_vpn   = vpn;
      req_valid = 1'b1;
      start     = rd_total;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      w_lat = 1;
      while (!resp_valid && w_lat < 2000) begin
         flush_req = (w_lat == flush_at);
         @(negedge clk);
         w_lat++;
      end
      flush_req = 1'b0;
      w_fault = resp_fault;
      w_lvl   = resp_level;
      w_pte   = resp_pte;
      w_reads = rd_total - start;
      if (!resp_valid) check(1'b0, "R12", "walk never responded", 0, 1);
      @(negedge clk);
   endtask

   task automatic idle_flush();
      @(negedge clk);
      flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
   endtask

   localparam logic [63:0] LEAF_A  = (64'h0ABCDE << 10) | 64'h7;
   localparam logic [63:0] LEAF_SP = (64'h77 << 10) | 64'h3;

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 1);
      check(resp_valid == 1'b0, "R1", "resp_valid after reset", 64'(resp_valid), 0);
      check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 0);
   endtask

   task automatic t_cold_and_warm();
      walk(mk_vpn(1, 2, 3, 4), 0);
      check(w_fault == 1'b0, "R2", "cold walk fault", 64'(w_fault), 0);
      check(w_pte == LEAF_A, "R2", "cold walk leaf", w_pte, LEAF_A);
      check(w_lvl == 2'd0, "R2", "cold walk level", 64'(w_lvl), 0);
      check(w_reads == 4, "R2", "cold walk reads", 64'(w_reads), 4);
      check(last_addr == eaddr(44'h400, 4), "R2", "level-0 address", 64'(last_addr),
            64'(eaddr(44'h400, 4)));
      walk(mk_vpn(1, 2, 3, 4), 0);
      check(w_reads == 0, "R5", "warm walk reads", 64'(w_reads), 0);
      check(w_pte == LEAF_A, "R5", "warm walk leaf", w_pte, LEAF_A);
   endtask

   task automatic t_uncached();
      @(negedge clk);
      mode_uncached = 1'b1;
      walk(mk_vpn(1, 2, 3, 4), 0);
      check(w_reads == 4, "R7", "uncached walk 1 reads", 64'(w_reads), 4);
      check(w_pte == LEAF_A, "R7", "uncached walk leaf", w_pte, LEAF_A);
      walk(mk_vpn(1, 2, 3, 4), 0);
      check(w_reads == 4, "R7", "uncached walk 2 reads", 64'(w_reads), 4);
      mode_uncached = 1'b0;
      walk(mk_vpn(1, 2, 3, 4), 0);
      check(w_reads == 0, "R7", "store kept across uncached mode", 64'(w_reads), 0);
   endtask

   task automatic t_flush();
      walk(mk_vpn(1, 2, 3, 4), 2);
      check(w_reads == 0, "R9", "flush mid-walk deferred", 64'(w_reads), 0);
      check(w_pte == LEAF_A, "R9", "flush mid-walk result", w_pte, LEAF_A);
      walk(mk_vpn(1, 2, 3, 4), 0);
      check(w_reads == 4, "R9", "deferred flush applied", 64'(w_reads), 4);
      idle_flush();
      walk(mk_vpn(1, 2, 3, 4), 0);
      check(w_reads == 4, "R9", "idle flush applied", 64'(w_reads), 4);
   endtask

   task automatic t_faults();
      walk(mk_vpn(1, 2, 5, 0), 0);
      check(w_fault == 1'b1, "R4", "invalid entry fault", 64'(w_fault), 1);
      check(w_reads == 1, "R4", "invalid entry reads", 64'(w_reads), 1);
      check(last_addr == eaddr(44'h300, 5), "R2", "level-1 address", 64'(last_addr),
            64'(eaddr(44'h300, 5)));
      walk(mk_vpn(1, 2, 5, 0), 0);
      check(w_reads == 1, "R6", "invalid entry not stored", 64'(w_reads), 1);
      walk(mk_vpn(1, 2, 3, 6), 0);
      check(w_fault == 1'b1, "R4", "non-leaf at level 0 fault", 64'(w_fault), 1);
      check(w_reads == 1, "R4", "non-leaf at level 0 reads", 64'(w_reads), 1);
      walk(mk_vpn(1, 2, 3, 6), 0);
      check(w_fault == 1'b1 && w_reads == 0, "R5", "valid non-leaf served from store",
            64'(w_reads), 0);
   endtask

   task automatic t_superpage();
      walk(mk_vpn(1, 7, 0, 0), 0);
      check(w_fault == 1'b0, "R3", "superpage fault", 64'(w_fault), 0);
      check(w_lvl == 2'd2, "R3", "superpage level", 64'(w_lvl), 2);
      check(w_pte == LEAF_SP, "R3", "superpage entry", w_pte, LEAF_SP);
      check(w_reads == 1, "R3", "superpage reads", 64'(w_reads), 1);
   endtask

   task automatic t_round_robin();
      idle_flush();
      for (int k = 0; k < 16; k++) begin
         walk(mk_vpn(100 + k, 0, 0, 0), 0);
         check(w_reads == 1 && w_lvl == 2'd3 && w_pte == mk_leaf(44'(32'h1000 + k), 4'h9),
               "R8", "fill walk", 64'(w_reads), 1);
      end
      walk(mk_vpn(100, 0, 0, 0), 0);
      check(w_reads == 0, "R8", "slot 0 holds k=0", 64'(w_reads), 0);
      check(w_lat == 3, "R10", "top-level hit latency", 64'(w_lat), 3);
      walk(mk_vpn(116, 0, 0, 0), 0);
      check(w_reads == 1, "R8", "17th entry misses", 64'(w_reads), 1);
      walk(mk_vpn(115, 0, 0, 0), 0);
      check(w_reads == 0, "R8", "k=15 still held", 64'(w_reads), 0);
      walk(mk_vpn(100, 0, 0, 0), 0);
      check(w_reads == 1, "R8", "k=0 replaced first", 64'(w_reads), 1);
      walk(mk_vpn(102, 0, 0, 0), 0);
      check(w_reads == 0, "R8", "k=2 still held", 64'(w_reads), 0);
      walk(mk_vpn(101, 0, 0, 0), 0);
      check(w_reads == 1, "R8", "k=1 replaced second", 64'(w_reads), 1);
   endtask

   // ---------------- main ----------------
   initial begin
      pmem[eaddr(44'h100, 1)] = mk_ptr(44'h200);
      pmem[eaddr(44'h200, 2)] = mk_ptr(44'h300);
      pmem[eaddr(44'h300, 3)] = mk_ptr(44'h400);
      pmem[eaddr(44'h400, 4)] = LEAF_A;
      pmem[eaddr(44'h400, 6)] = mk_ptr(44'h500);
      pmem[eaddr(44'h200, 7)] = LEAF_SP;
      for (int k = 0; k < 17; k++)
         pmem[eaddr(44'h100, 100 + k)] = mk_leaf(44'(32'h1000 + k), 4'h9);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cold_and_warm();
      t_uncached();
      t_flush();
      t_faults();
      t_superpage();
      t_round_robin();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule